// File: doc/BRIEF.md
# Instruction Prefetch Queue Unit

This block is a small byte queue that sits between a bus interface and an instruction-consuming execution unit. It keeps a fetch pointer into code space and raises one code-fetch request at a time on a request/acknowledge port. The size of each fetch depends on the alignment of the pointer. A fetch at an even address returns a 16-bit word, and both of its bytes are queued. A fetch at an odd address delivers only the upper byte lane. The pointer advances by the number of bytes accepted.

The consumer sees the oldest byte and a valid flag, and pops it with a one-cycle strobe. With each pop it marks whether the byte starts a new instruction. Every cycle the block reports a 2-bit status describing what happened to the queue on the previous clock edge. A flush input empties the queue, reloads the fetch pointer with a new code address, and causes the data of any fetch still in flight to be dropped. Fetching and consumption overlap freely. A new fetch is launched only when at least two slots will be free, so a word fetch can never overrun the queue.

Top module: `prefetch_queue`

## Requirements
- R1: While reset is asserted, `fetch_req_o`, `head_valid_o` and `qstat_o` are all 0. In the first cycle after reset is released, a request is raised at address `RESET_ADDR`.
- R2: The queue never holds more than `DEPTH` bytes. A new request is raised only when the byte count after the current edge leaves at least two of the `DEPTH` slots free.
- R3: At most one request is outstanding. `fetch_req_o` stays high with `fetch_addr_o` unchanged until a cycle in which `fetch_ack_i` is high.
- R4: When a request at an odd address is acknowledged, one byte is queued from `fetch_data_i[15:8]` and the pointer advances by 1. At an even address, `fetch_data_i[7:0]` is queued and then `fetch_data_i[15:8]`, and the pointer advances by 2. `fetch_word_o` is 1 exactly when the requested address is even.
- R5: Bytes leave in the order they were queued. `head_byte_o` shows the oldest byte whenever `head_valid_o` is 1, and a pop removes it at the clock edge.
- R6: In the cycle after a successful pop, `qstat_o` is 2'b01 if `pop_first_i` was 1, and 2'b11 if it was 0. After a cycle with no pop and no flush, `qstat_o` is 2'b00.
- R7: In the cycle after `flush_i`, `qstat_o` is 2'b10 and the queue is empty. The next new request uses `flush_addr_i`.
- R8: If a request is outstanding when a flush occurs, its acknowledge is still awaited with the old address held. Its data are discarded, and a request at the flush address follows.
- R9: A pop while `head_valid_o` is 0 changes nothing. The next `qstat_o` is 2'b00.
- R10: When a flush and a pop occur in the same cycle, the flush takes effect and the next `qstat_o` is 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Discard contents and reload the fetch pointer |
| flush_addr_i | input | AW | New code address loaded on flush |
| fetch_req_o | output | 1 | Code fetch request, held until acknowledged |
| fetch_addr_o | output | AW | Byte address of the requested fetch |
| fetch_word_o | output | 1 | 1 when the fetch returns two bytes (even address) |
| fetch_ack_i | input | 1 | Fetch data valid on this cycle |
| fetch_data_i | input | 16 | Fetch data, even byte on [7:0], odd byte on [15:8] |
| pop_i | input | 1 | Consumer takes the head byte |
| pop_first_i | input | 1 | The popped byte starts an instruction |
| head_valid_o | output | 1 | Queue holds at least one byte |
| head_byte_o | output | 8 | Oldest byte in the queue |
| qstat_o | output | 2 | Status of the previous edge: 00 none, 01 first byte, 10 flushed, 11 subsequent byte |

## Verification
The bench drives a flush while a fetch is still awaiting its acknowledge. A design that queued the late data, or moved the request address mid-handshake, would put stale bytes ahead of the new code stream. The bench starts at an odd address and then crosses into even ones, so taking the wrong byte lane or advancing the pointer by the wrong amount shows up as a byte-order error. It pops at the moment the queue runs dry and again while it is empty, which catches a phantom pop status or an underflowing count. It also fills the queue to within one slot of full with pops arriving on the same edge as acknowledges, so a request issued on stale occupancy would overflow or stall where the reference model does not.

// File: rtl/pq_pkg.sv
package pq_pkg;

    typedef enum logic [1:0] {
        QS_IDLE  = 2'b00,
        QS_FIRST = 2'b01,
        QS_FLUSH = 2'b10,
        QS_NEXT  = 2'b11
    } qstat_e;

endpackage

// File: rtl/pq_ring.sv
module pq_ring #(
    parameter int DEPTH = 6,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic [1:0]    push_cnt_i,
    input  logic [7:0]    push_lo_i,
    input  logic [7:0]    push_hi_i,
    input  logic          pop_i,
    output logic [7:0]    head_o,
    output logic [CW-1:0] count_o
);

    typedef struct packed {
        logic [IW-1:0] rd;
        logic [IW-1:0] wr;
        logic [CW-1:0] cnt;
    } ring_t;

    ring_t ring_d, ring_q;
    logic [7:0] mem_q [DEPTH];

    function automatic logic [IW-1:0] step_idx(input logic [IW-1:0] idx, input int inc);
        int s;
        s = int'(idx) + inc;
        if (s >= DEPTH) s = s - DEPTH;
        return IW'(s);
    endfunction

    always_comb begin
        ring_d = ring_q;
        if (clr_i) begin
            ring_d = '0;
        end else begin
            if (push_cnt_i != 2'd0) ring_d.wr = step_idx(ring_q.wr, int'(push_cnt_i));
            if (pop_i)              ring_d.rd = step_idx(ring_q.rd, 1);
            ring_d.cnt = ring_q.cnt + CW'(push_cnt_i) - CW'(pop_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ring_q <= '0;
        else        ring_q <= ring_d;
    end

    always_ff @(posedge clk) begin
        if (!clr_i) begin
            if (push_cnt_i != 2'd0) mem_q[ring_q.wr] <= push_lo_i;
            if (push_cnt_i == 2'd2) mem_q[step_idx(ring_q.wr, 1)] <= push_hi_i;
        end
    end

    assign head_o  = mem_q[ring_q.rd];
    assign count_o = ring_q.cnt;

    // R2: occupancy never exceeds the depth, including what arrives this edge
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(ring_q.cnt) + int'(push_cnt_i) - int'(pop_i)) <= DEPTH);

    // R9: the ring is never asked to give up a byte it does not hold
    a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (ring_q.cnt != '0));

endmodule

// File: rtl/pq_fetch_ctl.sv
module pq_fetch_ctl #(
    parameter int          DEPTH      = 6,
    parameter int          AW         = 20,
    parameter logic [AW-1:0] RESET_ADDR = '0,
    localparam int         CW         = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_i,
    input  logic [AW-1:0] flush_addr_i,
    input  logic          ack_i,
    input  logic [CW-1:0] count_i,
    input  logic          pop_ok_i,
    output logic          req_o,
    output logic [AW-1:0] addr_o,
    output logic          word_o,
    output logic [1:0]    push_cnt_o
);

    typedef struct packed {
        logic [AW-1:0] ptr;
        logic [AW-1:0] faddr;
        logic          req;
        logic          stale;
    } fctl_t;

    fctl_t st_d, st_q;
    logic       take;
    logic [1:0] step;
    int         cnt_next;

    always_comb begin
        st_d     = st_q;
        take     = st_q.req && ack_i && !st_q.stale && !flush_i;
        step     = st_q.faddr[0] ? 2'd1 : 2'd2;
        push_cnt_o = take ? step : 2'd0;

        if (st_q.req && ack_i) begin
            st_d.req   = 1'b0;
            st_d.stale = 1'b0;
        end
        if (take) st_d.ptr = st_q.faddr + {{(AW-2){1'b0}}, step};
        if (flush_i) begin
            st_d.ptr = flush_addr_i;
            if (st_q.req && !ack_i) st_d.stale = 1'b1;
        end

        if (flush_i) cnt_next = 0;
        else         cnt_next = int'(count_i) + int'(push_cnt_o) - int'(pop_ok_i);

        if (!st_d.req && ((DEPTH - cnt_next) >= 2)) begin
            st_d.req   = 1'b1;
            st_d.faddr = st_d.ptr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ptr   <= RESET_ADDR;
            st_q.faddr <= RESET_ADDR;
            st_q.req   <= 1'b0;
            st_q.stale <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_o  = st_q.req;
    assign addr_o = st_q.faddr;
    assign word_o = !st_q.faddr[0];

    // R3: an unanswered request keeps its address
    a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.req && !ack_i) |=> (st_q.req && $stable(st_q.faddr)));

    // R2: a fresh request only appears with two slots free
    a_r2_issue_room: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.req && !$past(st_q.req)) |-> (int'(count_i) <= DEPTH - 2));

    // R4: accepted data moves the pointer by the alignment-dependent size
    a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.req && ack_i && !st_q.stale && !flush_i) |=>
        ((st_q.ptr - $past(st_q.faddr)) == ($past(st_q.faddr[0]) ? AW'(1) : AW'(2))));

    // R8: an acknowledge belonging to a flushed request queues nothing
    a_r8_stale_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stale && ack_i) |-> (push_cnt_o == 2'd0));

endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue #(
    parameter int            DEPTH      = 6,
    parameter int            AW         = 20,
    parameter logic [AW-1:0] RESET_ADDR = '0,
    localparam int           CW         = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_i,
    input  logic [AW-1:0] flush_addr_i,
    output logic          fetch_req_o,
    output logic [AW-1:0] fetch_addr_o,
    output logic          fetch_word_o,
    input  logic          fetch_ack_i,
    input  logic [15:0]   fetch_data_i,
    input  logic          pop_i,
    input  logic          pop_first_i,
    output logic          head_valid_o,
    output logic [7:0]    head_byte_o,
    output logic [1:0]    qstat_o
);
    import pq_pkg::*;

    typedef struct packed {
        qstat_e qs;
    } top_t;

    top_t       top_d, top_q;
    logic [CW-1:0] count;
    logic       pop_ok;
    logic [1:0] push_cnt;
    logic [7:0] push_lo;

    assign head_valid_o = (count != '0);
    assign pop_ok       = pop_i && head_valid_o && !flush_i;
    assign push_lo      = fetch_addr_o[0] ? fetch_data_i[15:8] : fetch_data_i[7:0];

    pq_fetch_ctl #(.DEPTH(DEPTH), .AW(AW), .RESET_ADDR(RESET_ADDR)) u_fetch (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush_i      (flush_i),
        .flush_addr_i (flush_addr_i),
        .ack_i        (fetch_ack_i),
        .count_i      (count),
        .pop_ok_i     (pop_ok),
        .req_o        (fetch_req_o),
        .addr_o       (fetch_addr_o),
        .word_o       (fetch_word_o),
        .push_cnt_o   (push_cnt)
    );

    pq_ring #(.DEPTH(DEPTH)) u_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (flush_i),
        .push_cnt_i (push_cnt),
        .push_lo_i  (push_lo),
        .push_hi_i  (fetch_data_i[15:8]),
        .pop_i      (pop_ok),
        .head_o     (head_byte_o),
        .count_o    (count)
    );

    always_comb begin
        top_d = top_q;
        if (flush_i)     top_d.qs = QS_FLUSH;
        else if (pop_ok) top_d.qs = pop_first_i ? QS_FIRST : QS_NEXT;
        else             top_d.qs = QS_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q.qs <= QS_IDLE;
        else        top_q    <= top_d;
    end

    assign qstat_o = top_q.qs;

    // R6: a real pop is reported with the consumer's first-byte mark
    a_r6_pop_status: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && head_valid_o && !flush_i) |=>
        (qstat_o == ($past(pop_first_i) ? 2'b01 : 2'b11)));

    // R7 / R10: a flush empties the queue and wins over a pop
    a_r7_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (qstat_o == 2'b10 && !head_valid_o));

    // R9: popping an empty queue is reported as no operation
    a_r9_empty_pop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !head_valid_o && !flush_i) |=> (qstat_o == 2'b00));

endmodule

// File: tb/prefetch_queue_tb.sv
module prefetch_queue_tb;

    localparam int          DEPTH = 6;
    localparam int          AW    = 20;
    localparam logic [19:0] RST_A = 20'h00101;
    localparam int          AMASK = 32'hFFFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush_i = 1'b0;
    logic [19:0] flush_addr_i = '0;
    logic        fetch_req_o;
    logic [19:0] fetch_addr_o;
    logic        fetch_word_o;
    logic        fetch_ack_i = 1'b0;
    logic [15:0] fetch_data_i = '0;
    logic        pop_i = 1'b0;
    logic        pop_first_i = 1'b0;
    logic        head_valid_o;
    logic [7:0]  head_byte_o;
    logic [1:0]  qstat_o;

    always #2.5 clk = ~clk;   // 200 MHz

    prefetch_queue #(.DEPTH(DEPTH), .AW(AW), .RESET_ADDR(RST_A)) u_dut (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .flush_addr_i(flush_addr_i),
        .fetch_req_o(fetch_req_o), .fetch_addr_o(fetch_addr_o), .fetch_word_o(fetch_word_o),
        .fetch_ack_i(fetch_ack_i), .fetch_data_i(fetch_data_i),
        .pop_i(pop_i), .pop_first_i(pop_first_i),
        .head_valid_o(head_valid_o), .head_byte_o(head_byte_o), .qstat_o(qstat_o)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    function automatic logic [7:0] code_byte(input int a);
        return 8'(a) ^ 8'(a >> 8) ^ 8'h3C;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- bus responder ----------------
    int lat = 0;
    int wcnt = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            fetch_ack_i = 1'b0;
            wcnt = 0;
        end else if (fetch_ack_i) begin
            fetch_ack_i = 1'b0;
        end else if (fetch_req_o) begin
            if (wcnt >= lat) begin
                fetch_ack_i  = 1'b1;
                fetch_data_i = {code_byte(int'(fetch_addr_o) | 1), code_byte(int'(fetch_addr_o) & ~1)};
                wcnt = 0;
            end else begin
                wcnt++;
            end
        end
    end

    // ---------------- reference model ----------------
    logic [7:0] mq[$];
    int  mptr, maddr, mstat;
    bit  mreq, mstale, live;

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            mptr = int'(RST_A); maddr = int'(RST_A);
            mreq = 0; mstale = 0; mstat = 0;
        end else begin
            bit popok;
            popok = pop_i && (mq.size() > 0);
            if (flush_i) begin
                mq.delete();
                mstat = 2;
                if (mreq && !fetch_ack_i) mstale = 1;
                else begin mreq = 0; mstale = 0; end
                mptr = int'(flush_addr_i);
            end else begin
                if (popok) begin
                    void'(mq.pop_front());
                    mstat = pop_first_i ? 1 : 3;
                end else mstat = 0;
                if (mreq && fetch_ack_i) begin
                    if (!mstale) begin
                        mq.push_back(code_byte(maddr));
                        if (maddr % 2 == 0) begin
                            mq.push_back(code_byte(maddr + 1));
                            mptr = (maddr + 2) & AMASK;
                        end else mptr = (maddr + 1) & AMASK;
                    end
                    mreq = 0; mstale = 0;
                end
            end
            if (!mreq && (DEPTH - mq.size() >= 2)) begin
                mreq = 1; maddr = mptr;
            end
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (rst_n && live && !done) begin
            chk(fetch_req_o == mreq, "R3 req", int'(fetch_req_o), int'(mreq));
            if (mreq) begin
                chk(int'(fetch_addr_o) == maddr, "R4 addr", int'(fetch_addr_o), maddr);
                chk(fetch_word_o == (maddr % 2 == 0), "R4 word", int'(fetch_word_o), int'(maddr % 2 == 0));
            end
            chk(head_valid_o == (mq.size() > 0), "R2 valid", int'(head_valid_o), mq.size());
            if (mq.size() > 0)
                chk(head_byte_o == mq[0], "R5 head", int'(head_byte_o), int'(mq[0]));
            chk(int'(qstat_o) == mstat, "R6 qstat", int'(qstat_o), mstat);
        end
    end

    // ---------------- watchdog ----------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic drive(input bit p, input bit f, input bit fl, input logic [19:0] fa);
        pop_i = p; pop_first_i = f; flush_i = fl; flush_addr_i = fa;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0, '0);
    endtask

    logic [31:0] lfsr = 32'hACE1_2468;
    function automatic logic [31:0] nx(input logic [31:0] v);
        return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
    endfunction

    initial begin
        logic [19:0] old_a;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(fetch_req_o == 1'b0, "R1 req in reset", int'(fetch_req_o), 0);
        chk(head_valid_o == 1'b0, "R1 valid in reset", int'(head_valid_o), 0);
        chk(qstat_o == 2'b00, "R1 qstat in reset", int'(qstat_o), 0);
        rst_n = 1'b1;
        live = 1;
        @(negedge clk);
        chk(fetch_req_o == 1'b1, "R1 first req", int'(fetch_req_o), 1);
        chk(fetch_addr_o == RST_A, "R1 start addr", int'(fetch_addr_o), int'(RST_A));

        // fill with no consumer: odd start, then even words
        idle(12);
        chk(fetch_req_o == 1'b0, "R2 no req with one slot free", int'(fetch_req_o), 0);
        chk(head_byte_o == code_byte(int'(RST_A)), "R4 odd fetch upper lane", int'(head_byte_o), int'(code_byte(int'(RST_A))));

        drive(1, 1, 0, '0);
        chk(qstat_o == 2'b01, "R6 first byte status", int'(qstat_o), 1);
        chk(head_byte_o == code_byte(int'(RST_A) + 1), "R5 order low byte of word", int'(head_byte_o), int'(code_byte(int'(RST_A) + 1)));
        drive(1, 0, 0, '0);
        chk(qstat_o == 2'b11, "R6 subsequent byte status", int'(qstat_o), 3);
        chk(head_byte_o == code_byte(int'(RST_A) + 2), "R4 high byte of word", int'(head_byte_o), int'(code_byte(int'(RST_A) + 2)));
        idle(1);
        chk(qstat_o == 2'b00, "R6 idle status", int'(qstat_o), 0);

        // drain with slow bus, then pop on empty
        lat = 30;
        for (int i = 0; i < 20 && head_valid_o; i++) drive(1, 0, 0, '0);
        if (!head_valid_o) begin
            drive(1, 1, 0, '0);
            chk(qstat_o == 2'b00, "R9 pop on empty status", int'(qstat_o), 0);
        end

        // flush while a request waits
        idle(2);
        chk(fetch_req_o == 1'b1, "R8 request pending before flush", int'(fetch_req_o), 1);
        old_a = fetch_addr_o;
        drive(0, 0, 1, 20'h02000);
        flush_i = 1'b0;
        idle(1);
        chk(qstat_o == 2'b00, "R7 status settles after flush", int'(qstat_o), 0);
        chk(fetch_addr_o == old_a, "R8 old address held", int'(fetch_addr_o), int'(old_a));
        do @(posedge clk); while (!fetch_ack_i);
        @(negedge clk);
        chk(head_valid_o == 1'b0, "R8 stale data dropped", int'(head_valid_o), 0);
        chk(fetch_addr_o == 20'h02000, "R7 fetch at flush address", int'(fetch_addr_o), 'h2000);

        // flush and pop together
        lat = 0;
        idle(10);
        drive(1, 1, 1, 20'h00333);
        drive(0, 0, 0, '0);
        // qstat seen one negedge after the flush edge is checked by the model too
        chk(head_valid_o == 1'b0 || head_byte_o == code_byte('h333), "R10 flush wins over pop", int'(head_byte_o), int'(code_byte('h333)));

        // directed flush status check
        idle(6);
        pop_i = 1'b1; flush_i = 1'b1; flush_addr_i = 20'h00444;
        @(negedge clk);
        pop_i = 1'b0; flush_i = 1'b0;
        chk(qstat_o == 2'b10, "R10 flush status with pop", int'(qstat_o), 2);
        chk(head_valid_o == 1'b0, "R7 empty after flush", int'(head_valid_o), 0);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            lfsr = nx(lfsr);
            lat = int'(lfsr[3:2]) % 3;
            drive(lfsr[5] | lfsr[9], lfsr[7], (lfsr[15:10] == 6'd0), lfsr[31:12]);
        end
        idle(4);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule